// File: doc/BRIEF.md
# Translation Cache with Per-Access Permission Mask

This block is a direct-mapped cache of address translations for 32-bit linear addresses split into 4 KiB pages. A requester presents a linear address, its privilege (user or supervisor) and an access kind (read, write or read-modify-write). One cycle later the block answers with either a hit, carrying the physical address, or a miss. A miss tells the page walker to translate the address. The walker then installs the result through the fill port.

Each entry holds a four-bit mask of the operations it allows. The mask is built at fill time from the page's combined user/supervisor and read/write attributes and from whether the translating access was a write. A hit whose mask bit for the current access is clear is not a fault. It is reported as a miss, so the walker re-reads the page tables and raises any fault itself. As a result, write permission appears in an entry only after a write has been translated through it. A flush input invalidates every entry in one cycle. Two saturating counters track lookups and misses.

Top module: `tlb_perm_cache`

## Requirements
- R1: On a hit, `rsp_paddr` equals the stored physical frame in bits 31:12 joined with request bits 11:0, which pass through unchanged. It appears one cycle after the request. With no hit, `rsp_paddr` is zero.
- R2: A hit requires that the indexed entry is valid and that its stored tag equals the request's page number (address bits 31:12). Any other case answers with a miss.
- R3: The mask bit tested is number {is_write, is_user}. Bit 0 is read-supervisor, bit 1 read-user, bit 2 write-supervisor and bit 3 write-user. A matching entry whose bit is clear answers with a miss.
- R4: A fill for a user page (`fill_user`=1) grants read-user and read-supervisor. If `fill_by_write`=1, it also adds write-supervisor, and adds write-user as well when `fill_rw`=1.
- R5: A fill for a supervisor page (`fill_user`=0) grants read-supervisor only. It adds write-supervisor when `fill_by_write`=1, and never grants a user bit.
- R6: `req_kind` 2'b00 is a read. 2'b01 is a write, 2'b10 is a read-modify-write and 2'b11 is a write. Both the read-modify-write and the write codes test the write bits.
- R7: A flush invalidates all entries at the next clock edge. A fill in the same cycle as a flush is discarded.
- R8: `lookup_count` counts accepted requests and `miss_count` counts requests answered with a miss, permission misses included. Each counter becomes visible with the response and holds at all ones rather than wrapping.
- R9: After reset, no entry is valid, `rsp_hit` and `rsp_miss` are low and both counters are zero.
- R10: The cycle after each request, exactly one of `rsp_hit` and `rsp_miss` is high. After a cycle without a request, both are low.
- R11: The entry index is the low log2(ENTRIES) bits of the page number. A fill evicts any entry with the same index. A lookup in the same cycle as a fill sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Translation request present |
| req_laddr | input | ADDR_W | Linear address of the request |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 read-modify-write, 11 write |
| fill_valid | input | 1 | Install a translation |
| fill_laddr | input | ADDR_W | Linear address whose page is being filled |
| fill_frame | input | ADDR_W-PAGE_BITS | Physical frame number |
| fill_user | input | 1 | Combined user/supervisor attribute (1 = user page) |
| fill_rw | input | 1 | Combined read/write attribute (1 = writable) |
| fill_by_write | input | 1 | The translating access was a write |
| rsp_hit | output | 1 | Permitted hit, one cycle after the request |
| rsp_miss | output | 1 | Miss or permission miss; walk required |
| rsp_paddr | output | ADDR_W | Physical address on a hit, zero otherwise |
| lookup_count | output | CNT_W | Saturating count of requests |
| miss_count | output | CNT_W | Saturating count of misses |

## Verification
A stored mask built from the wrong attribute shows up on the first lookup of that page by the privilege/access pair it affects: a hit appears where a miss was due, or the reverse. A stale valid bit or tag after a flush or an aliasing fill produces a false hit with the wrong frame on the very next lookup of that index. Counter faults show on the response cycle of any request. Saturation shows once the count passes its all-ones value.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

    typedef enum logic [1:0] {
        ACC_READ   = 2'b00,
        ACC_WRITE  = 2'b01,
        ACC_RMW    = 2'b10,
        ACC_WRITE2 = 2'b11
    } acc_kind_e;

    typedef logic [3:0] perm_mask_t;

    localparam int PERM_RD_SUP = 0;
    localparam int PERM_RD_USR = 1;
    localparam int PERM_WR_SUP = 2;
    localparam int PERM_WR_USR = 3;

    function automatic logic kind_writes(input logic [1:0] kind);
        return kind != ACC_READ;
    endfunction

    function automatic logic [1:0] perm_sel(input logic is_write, input logic is_user);
        return {is_write, is_user};
    endfunction

    function automatic perm_mask_t build_mask(input logic user_page,
                                              input logic page_rw,
                                              input logic by_write);
        perm_mask_t m;
        m = '0;
        m[PERM_RD_SUP] = 1'b1;
        if (user_page) begin
            m[PERM_RD_USR] = 1'b1;
            if (by_write) begin
                m[PERM_WR_SUP] = 1'b1;
                m[PERM_WR_USR] = page_rw;
            end
        end else if (by_write) begin
            m[PERM_WR_SUP] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/tlbp_entry_array.sv
module tlbp_entry_array
    import tlbp_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int TAG_W   = 20,
    parameter int FRAME_W = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [FRAME_W-1:0] wr_frame,
    input  perm_mask_t         wr_mask,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_valid,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [FRAME_W-1:0] rd_frame,
    output perm_mask_t         rd_mask
);

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] wr_sel;
    logic [TAG_W-1:0]   tag_q   [ENTRIES];
    logic [FRAME_W-1:0] frame_q [ENTRIES];
    perm_mask_t         mask_q  [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_sel
        assign wr_sel[e] = wr_en && !flush && (wr_idx == IDX_W'(e));
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_q | wr_sel;
        end
    end

    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (wr_sel[e]) begin
                tag_q[e]   <= wr_tag;
                frame_q[e] <= wr_frame;
                mask_q[e]  <= wr_mask;
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_frame = frame_q[rd_idx];
    assign rd_mask  = mask_q[rd_idx];

endmodule

// File: rtl/tlbp_lookup.sv
module tlbp_lookup
    import tlbp_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    localparam int VPN_W    = ADDR_W - PAGE_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [VPN_W-1:0]     req_vpn,
    input  logic [PAGE_BITS-1:0] req_off,
    input  logic                 req_write,
    input  logic                 req_user,
    input  logic                 ent_valid,
    input  logic [VPN_W-1:0]     ent_tag,
    input  logic [VPN_W-1:0]     ent_frame,
    input  perm_mask_t           ent_mask,
    output logic                 hit_now,
    output logic                 rsp_hit,
    output logic                 rsp_miss,
    output logic [ADDR_W-1:0]    rsp_paddr
);

    logic tag_match;
    logic perm_ok;

    assign tag_match = ent_valid && (ent_tag == req_vpn);
    assign perm_ok   = ent_mask[perm_sel(req_write, req_user)];
    assign hit_now   = tag_match && perm_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_hit   <= req_valid && hit_now;
            rsp_miss  <= req_valid && !hit_now;
            rsp_paddr <= (req_valid && hit_now) ? {ent_frame, req_off} : '0;
        end
    end

endmodule

// File: rtl/tlbp_sat_counter.sv
module tlbp_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc && (count != {W{1'b1}})) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/tlb_perm_cache.sv
module tlb_perm_cache
    import tlbp_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int ENTRIES   = 32,
    parameter int CNT_W     = 32,
    localparam int VPN_W    = ADDR_W - PAGE_BITS,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_laddr,
    input  logic              req_user,
    input  logic [1:0]        req_kind,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_laddr,
    input  logic [VPN_W-1:0]  fill_frame,
    input  logic              fill_user,
    input  logic              fill_rw,
    input  logic              fill_by_write,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [CNT_W-1:0]  lookup_count,
    output logic [CNT_W-1:0]  miss_count
);

    logic [VPN_W-1:0] req_vpn;
    logic [VPN_W-1:0] fill_vpn;
    logic             req_write;
    logic             ent_valid;
    logic [VPN_W-1:0] ent_tag;
    logic [VPN_W-1:0] ent_frame;
    perm_mask_t       ent_mask;
    perm_mask_t       fill_mask;
    logic             hit_now;

    assign req_vpn   = req_laddr[ADDR_W-1:PAGE_BITS];
    assign fill_vpn  = fill_laddr[ADDR_W-1:PAGE_BITS];
    assign req_write = kind_writes(req_kind);
    assign fill_mask = build_mask(fill_user, fill_rw, fill_by_write);

    tlbp_entry_array #(
        .ENTRIES (ENTRIES),
        .TAG_W   (VPN_W),
        .FRAME_W (VPN_W)
    ) i_array (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (fill_valid),
        .wr_idx   (fill_vpn[IDX_W-1:0]),
        .wr_tag   (fill_vpn),
        .wr_frame (fill_frame),
        .wr_mask  (fill_mask),
        .rd_idx   (req_vpn[IDX_W-1:0]),
        .rd_valid (ent_valid),
        .rd_tag   (ent_tag),
        .rd_frame (ent_frame),
        .rd_mask  (ent_mask)
    );

    tlbp_lookup #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS)
    ) i_lookup (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_vpn   (req_vpn),
        .req_off   (req_laddr[PAGE_BITS-1:0]),
        .req_write (req_write),
        .req_user  (req_user),
        .ent_valid (ent_valid),
        .ent_tag   (ent_tag),
        .ent_frame (ent_frame),
        .ent_mask  (ent_mask),
        .hit_now   (hit_now),
        .rsp_hit   (rsp_hit),
        .rsp_miss  (rsp_miss),
        .rsp_paddr (rsp_paddr)
    );

    tlbp_sat_counter #(.W(CNT_W)) i_lookup_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (req_valid),
        .count (lookup_count)
    );

    tlbp_sat_counter #(.W(CNT_W)) i_miss_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (req_valid && !hit_now),
        .count (miss_count)
    );

endmodule

// File: rtl/tlbp_checker.sv
module tlbp_checker #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int CNT_W     = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              flush,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_laddr,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [CNT_W-1:0]  lookup_count,
    input logic [CNT_W-1:0]  miss_count
);

    // R10
    one_answer_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_hit ^ rsp_miss));

    // R10
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_hit && !rsp_miss));

    // R1
    offset_through_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_paddr[PAGE_BITS-1:0] == $past(req_laddr[PAGE_BITS-1:0])));

    // R1
    zero_addr_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_paddr == '0));

    // R7
    miss_after_flush_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(flush) && req_valid) |=> rsp_miss);

    // R8
    miss_count_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        miss_count >= $past(miss_count));

    // R8
    misses_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        miss_count <= lookup_count);

    // R8
    lookup_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(lookup_count));

endmodule

bind tlb_perm_cache tlbp_checker #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .CNT_W     (CNT_W)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush),
    .req_valid    (req_valid),
    .req_laddr    (req_laddr),
    .rsp_hit      (rsp_hit),
    .rsp_miss     (rsp_miss),
    .rsp_paddr    (rsp_paddr),
    .lookup_count (lookup_count),
    .miss_count   (miss_count)
);

// File: tb/test_tlb_perm_cache.sv
module test_tlb_perm_cache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_laddr = '0;
    logic        req_user = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_laddr = '0;
    logic [19:0] fill_frame = '0;
    logic        fill_user = 1'b0;
    logic        fill_rw = 1'b0;
    logic        fill_by_write = 1'b0;

    logic        rsp_hit, rsp_miss;
    logic [31:0] rsp_paddr;
    logic [31:0] lookup_count, miss_count;

    logic        n_hit, n_miss;
    logic [31:0] n_paddr;
    logic [2:0]  n_lookups, n_misses;

    int checks = 0;
    int fails  = 0;
    int exp_lk = 0;
    int exp_ms = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    tlb_perm_cache i_tlb_perm_cache (
        .clk(clk), .rst(rst), .flush(flush),
        .req_valid(req_valid), .req_laddr(req_laddr), .req_user(req_user), .req_kind(req_kind),
        .fill_valid(fill_valid), .fill_laddr(fill_laddr), .fill_frame(fill_frame),
        .fill_user(fill_user), .fill_rw(fill_rw), .fill_by_write(fill_by_write),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr),
        .lookup_count(lookup_count), .miss_count(miss_count)
    );

    tlb_perm_cache #(.CNT_W(3)) i_tlb_perm_cache_narrow (
        .clk(clk), .rst(rst), .flush(flush),
        .req_valid(req_valid), .req_laddr(req_laddr), .req_user(req_user), .req_kind(req_kind),
        .fill_valid(fill_valid), .fill_laddr(fill_laddr), .fill_frame(fill_frame),
        .fill_user(fill_user), .fill_rw(fill_rw), .fill_by_write(fill_by_write),
        .rsp_hit(n_hit), .rsp_miss(n_miss), .rsp_paddr(n_paddr),
        .lookup_count(n_lookups), .miss_count(n_misses)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic [31:0] la, input logic user, input logic [1:0] kind,
                          input bit exp_hit, input logic [31:0] exp_pa, input string req);
        logic [31:0] want;
        @(negedge clk);
        req_valid = 1'b1; req_laddr = la; req_user = user; req_kind = kind;
        @(negedge clk);
        req_valid = 1'b0;
        want = exp_hit ? exp_pa : 32'h0;
        exp_lk++;
        if (!exp_hit) exp_ms++;
        chk(rsp_hit == exp_hit && rsp_miss == !exp_hit && rsp_paddr == want, req,
            {31'h0, rsp_hit, rsp_paddr}, {31'h0, exp_hit, want});
    endtask

    task automatic do_fill(input logic [31:0] la, input logic [19:0] frame,
                           input logic user, input logic rw, input logic by_wr);
        @(negedge clk);
        fill_valid = 1'b1; fill_laddr = la; fill_frame = frame;
        fill_user = user; fill_rw = rw; fill_by_write = by_wr;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk(!rsp_hit && !rsp_miss, "R9 outputs", {62'h0, rsp_hit, rsp_miss}, 64'h0);
        chk(lookup_count == 0 && miss_count == 0, "R9 counters",
            {lookup_count, miss_count}, 64'h0);
        do_req(32'h0000_5123, 1'b0, 2'b00, 0, 0, "R9 R2 cold miss");
    endtask

    task automatic t_user_page();
        do_fill(32'h0000_5000, 20'hABCDE, 1'b1, 1'b1, 1'b0);
        do_req(32'h0000_5123, 1'b1, 2'b00, 1, 32'hABCD_E123, "R1 R4 read user");
        do_req(32'h0000_5FFF, 1'b0, 2'b00, 1, 32'hABCD_EFFF, "R1 R4 read sup");
        do_req(32'h0000_5123, 1'b1, 2'b01, 0, 0, "R3 write user before write fill");
        do_req(32'h0000_5123, 1'b0, 2'b01, 0, 0, "R3 write sup before write fill");
        do_fill(32'h0000_5000, 20'hABCDE, 1'b1, 1'b1, 1'b1);
        do_req(32'h0000_5004, 1'b1, 2'b01, 1, 32'hABCD_E004, "R4 write user rw=1");
        do_req(32'h0000_5008, 1'b0, 2'b11, 1, 32'hABCD_E008, "R4 R6 write sup code 11");
        do_req(32'h0000_500C, 1'b1, 2'b10, 1, 32'hABCD_E00C, "R6 rmw user");
        do_fill(32'h0000_5000, 20'h11111, 1'b1, 1'b0, 1'b1);
        do_req(32'h0000_5010, 1'b1, 2'b01, 0, 0, "R4 write user rw=0");
        do_req(32'h0000_5010, 1'b1, 2'b10, 0, 0, "R4 R6 rmw user rw=0");
        do_req(32'h0000_5010, 1'b0, 2'b01, 1, 32'h1111_1010, "R4 write sup rw=0");
    endtask

    task automatic t_sup_page();
        do_fill(32'h0000_7000, 20'h12345, 1'b0, 1'b1, 1'b0);
        do_req(32'h0000_7ABC, 1'b0, 2'b00, 1, 32'h1234_5ABC, "R5 read sup");
        do_req(32'h0000_7ABC, 1'b1, 2'b00, 0, 0, "R5 R3 read user on sup page");
        do_req(32'h0000_7ABC, 1'b0, 2'b01, 0, 0, "R5 write sup before write fill");
        do_fill(32'h0000_7000, 20'h12345, 1'b0, 1'b1, 1'b1);
        do_req(32'h0000_7ABC, 1'b0, 2'b10, 1, 32'h1234_5ABC, "R5 R6 rmw sup");
        do_req(32'h0000_7ABC, 1'b1, 2'b01, 0, 0, "R5 write user never");
        do_req(32'h0000_7ABC, 1'b1, 2'b00, 0, 0, "R5 read user never");
    endtask

    task automatic t_alias();
        do_fill(32'h0002_5000, 20'h0BEEF, 1'b1, 1'b1, 1'b0);
        do_req(32'h0000_5123, 1'b0, 2'b00, 0, 0, "R11 R2 evicted alias");
        do_req(32'h0002_5123, 1'b0, 2'b00, 1, 32'h0BEE_F123, "R11 new tag hits");
        do_req(32'h0004_5123, 1'b0, 2'b00, 0, 0, "R2 tag mismatch same index");
    endtask

    task automatic t_same_cycle_fill();
        @(negedge clk);
        fill_valid = 1'b1; fill_laddr = 32'h0000_9000; fill_frame = 20'h55555;
        fill_user = 1'b1; fill_rw = 1'b1; fill_by_write = 1'b0;
        req_valid = 1'b1; req_laddr = 32'h0000_9321; req_user = 1'b0; req_kind = 2'b00;
        @(negedge clk);
        fill_valid = 1'b0; req_valid = 1'b0;
        exp_lk++; exp_ms++;
        chk(rsp_miss && !rsp_hit, "R11 lookup sees old contents",
            {62'h0, rsp_hit, rsp_miss}, 64'h1);
        do_req(32'h0000_9321, 1'b0, 2'b00, 1, 32'h5555_5321, "R11 hit after fill");
    endtask

    task automatic t_flush();
        do_fill(32'h0000_3000, 20'h33333, 1'b1, 1'b1, 1'b0);
        do_req(32'h0000_3001, 1'b1, 2'b00, 1, 32'h3333_3001, "R7 before flush");
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        do_req(32'h0000_3001, 1'b1, 2'b00, 0, 0, "R7 after flush");
        do_req(32'h0002_5123, 1'b0, 2'b00, 0, 0, "R7 other entry flushed");
        @(negedge clk);
        flush = 1'b1; fill_valid = 1'b1; fill_laddr = 32'h0000_3000; fill_frame = 20'h33333;
        fill_user = 1'b1; fill_rw = 1'b1; fill_by_write = 1'b0;
        @(negedge clk); flush = 1'b0; fill_valid = 1'b0;
        do_req(32'h0000_3001, 1'b1, 2'b00, 0, 0, "R7 fill discarded by flush");
    endtask

    task automatic t_idle_counts();
        @(negedge clk);
        chk(!rsp_hit && !rsp_miss, "R10 idle", {62'h0, rsp_hit, rsp_miss}, 64'h0);
        chk(lookup_count == 32'(exp_lk), "R8 lookups", 64'(lookup_count), 64'(exp_lk));
        chk(miss_count == 32'(exp_ms), "R8 misses", 64'(miss_count), 64'(exp_ms));
        chk(n_lookups == 3'((exp_lk > 7) ? 7 : exp_lk), "R8 lookup saturation",
            64'(n_lookups), 64'((exp_lk > 7) ? 7 : exp_lk));
        chk(n_misses == 3'((exp_ms > 7) ? 7 : exp_ms), "R8 miss saturation",
            64'(n_misses), 64'((exp_ms > 7) ? 7 : exp_ms));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_user_page();
        t_sup_page();
        t_alias();
        t_same_cycle_fill();
        t_flush();
        t_idle_counts();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule